// File: doc/BRIEF.md
# ECC Error Capture and Interrupt Register Block

This block sits beside a memory ECC decoder and keeps a record of the errors that the decoder reports. The decoder raises a one-cycle pulse for a correctable event or for an uncorrectable event. With each pulse it supplies the 34-bit memory address, the 64-bit data word, the 8-bit syndrome and the 14-bit identifier of the requester. Correctable and uncorrectable events each have their own capture bank. A bank loads only while its class has no pending status. It then stays frozen until software acknowledges that status, so the first error of a burst is the one kept.

Software reaches the block through a 32-bit word-addressed register port. Writes take effect at once. Reads return data one cycle after the request, together with a valid strobe. The port gives access to a control word with the ECC enable field, the status word, a write-one-to-clear acknowledge word, a master interrupt mask, the two capture banks and a shared source-ID word. One interrupt line is high while an unmasked status bit is set.

Register word indices: 0 control, 1 status, 2 acknowledge, 3 master mask, 4–7 correctable bank, 8–11 uncorrectable bank, 12 source ID. Within each bank the words are, in order: low address, high word, low data, high data. The high word holds syndrome[7:0] in bits [15:8] and address[33:32] in bits [1:0].

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every register reads 0 except the master mask, which reads 0xFFFFFFFF, and `irq` is low.
- R2: When capture is enabled and status bits [1:0] are clear, a pulse on `ev_ce` sets status bits [1:0] to 11. It also loads the correctable bank (words 4–7) with the event's address, syndrome and data, and loads source-ID bits [29:16] with the requester ID.
- R3: When capture is enabled and status bits [3:2] are clear, a pulse on `ev_ue` sets status bits [3:2] to 11. It also loads the uncorrectable bank (words 8–11) and loads source-ID bits [13:0] with the requester ID.
- R4: Writing ones to acknowledge word bits [1:0] or [3:2] clears the matching status bits, each bit on its own. The acknowledge word always reads 0.
- R5: While any status bit of a class is set, further events of that class are dropped, and that class's bank and source-ID field keep their contents.
- R6: Capture is enabled when control bits [17:16] are not both zero. Either bit alone is enough. When both are zero, events change neither status nor banks.
- R7: `irq` is high exactly when master mask bit 31 (global) is 0, master mask bit 2 (ECC group) is 0, and some status bit is set. Writing 0x7FFFFFFB to the mask enables only the ECC group.
- R8: A correctable and an uncorrectable event in the same cycle are both captured, each into its own bank and its own source-ID field.
- R9: The control word and the master mask read back what was written. Reads of word indices 13–15 return 0. Read data appears one cycle after `rd_en` and is marked by `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_idx | input | 4 | Word index of the register accessed |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| ev_ce | input | 1 | Correctable event pulse |
| ev_ue | input | 1 | Uncorrectable event pulse |
| ev_addr | input | 34 | Address of the failing access |
| ev_data | input | 64 | Data word of the failing access |
| ev_synd | input | 8 | Syndrome from the decoder |
| ev_src | input | 14 | Requester ID |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take the event pulses to be synchronous to `clk`, and they take any pulse to be meaningful only while its payload is stable in that same cycle. They also take it that software never writes and reads in the same cycle. The stimulus drives each event for exactly one clock with its payload, and it issues reads and writes one at a time on the falling edge. It repeats an event only after the status it caused has been read or acknowledged. This keeps every capture attributable to a single known pulse.

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int IW  = 4,
  parameter int AW  = 34,
  parameter int DW  = 64,
  parameter int SW  = 8,
  parameter int IDW = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [IW-1:0]  reg_idx,
  input  logic [31:0]    wr_data,
  output logic [31:0]    rd_data,
  output logic           rd_valid,
  input  logic           ev_ce,
  input  logic           ev_ue,
  input  logic [AW-1:0]  ev_addr,
  input  logic [DW-1:0]  ev_data,
  input  logic [SW-1:0]  ev_synd,
  input  logic [IDW-1:0] ev_src,
  output logic           irq
);
  localparam int AHW = AW - 32;
  localparam logic [IW-1:0] I_CTRL = 0, I_STAT = 1, I_ACK = 2, I_MASK = 3,
                            I_CE   = 4, I_UE   = 8, I_SRC = 12;

  logic [1:0]     en_fld;
  logic [31:0]    mask;
  logic [1:0]     ce_st, ue_st;
  logic [AW-1:0]  ce_a, ue_a;
  logic [DW-1:0]  ce_d, ue_d;
  logic [SW-1:0]  ce_s, ue_s;
  logic [IDW-1:0] ce_id, ue_id;

  wire cap_on = |en_fld;
  wire ce_cap = cap_on && ev_ce && ce_st == 2'b00;
  wire ue_cap = cap_on && ev_ue && ue_st == 2'b00;
  wire ack_wr = wr_en && reg_idx == I_ACK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_fld <= '0;
      mask   <= '1;
    end else if (wr_en) begin
      if (reg_idx == I_CTRL) en_fld <= wr_data[17:16];
      if (reg_idx == I_MASK) mask   <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_st <= '0;
      ue_st <= '0;
    end else begin
      if (ce_cap)      ce_st <= 2'b11;
      else if (ack_wr) ce_st <= ce_st & ~wr_data[1:0];
      if (ue_cap)      ue_st <= 2'b11;
      else if (ack_wr) ue_st <= ue_st & ~wr_data[3:2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_a <= '0; ce_d <= '0; ce_s <= '0; ce_id <= '0;
      ue_a <= '0; ue_d <= '0; ue_s <= '0; ue_id <= '0;
    end else begin
      if (ce_cap) begin
        ce_a <= ev_addr; ce_d <= ev_data; ce_s <= ev_synd; ce_id <= ev_src;
      end
      if (ue_cap) begin
        ue_a <= ev_addr; ue_d <= ev_data; ue_s <= ev_synd; ue_id <= ev_src;
      end
    end
  end

  logic [31:0] rmux;
  always_comb begin
    rmux = '0;
    case (reg_idx)
      I_CTRL:  rmux[17:16] = en_fld;
      I_STAT:  rmux[3:0] = {ue_st, ce_st};
      I_MASK:  rmux = mask;
      I_CE:    rmux = ce_a[31:0];
      I_CE+1:  begin rmux[15:8] = ce_s; rmux[AHW-1:0] = ce_a[AW-1:32]; end
      I_CE+2:  rmux = ce_d[31:0];
      I_CE+3:  rmux = ce_d[63:32];
      I_UE:    rmux = ue_a[31:0];
      I_UE+1:  begin rmux[15:8] = ue_s; rmux[AHW-1:0] = ue_a[AW-1:32]; end
      I_UE+2:  rmux = ue_d[31:0];
      I_UE+3:  rmux = ue_d[63:32];
      I_SRC:   begin rmux[16+IDW-1:16] = ce_id; rmux[IDW-1:0] = ue_id; end
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rmux;
    end
  end

  assign irq = !mask[31] && !mask[2] && |{ue_st, ce_st};

  AST_CE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_on && ev_ce && ce_st == 2'b00) |=> ce_st == 2'b11); // R2
  AST_UE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_on && ev_ue && ue_st == 2'b00) |=> ue_st == 2'b11); // R3
  AST_ACK_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && wr_data[1:0] == 2'b11 && ce_st != 2'b00) |=> ce_st == 2'b00); // R4
  AST_CE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_st != 2'b00) |=> ($stable(ce_a) && $stable(ce_d) && $stable(ce_id))); // R5
  AST_UE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_st != 2'b00) |=> ($stable(ue_a) && $stable(ue_d) && $stable(ue_id))); // R5
  AST_OFF_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_on && ce_st == 2'b00 && ue_st == 2'b00) |=> (ce_st == 2'b00 && ue_st == 2'b00)); // R6
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ce_st != 2'b00 || ue_st != 2'b00)); // R7
  AST_RD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R9
endmodule

// File: tb/ecc_err_log_test.sv
module ecc_err_log_test;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [3:0]  reg_idx = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        ev_ce = 0, ev_ue = 0;
  logic [33:0] ev_addr = 0;
  logic [63:0] ev_data = 0;
  logic [7:0]  ev_synd = 0;
  logic [13:0] ev_src = 0;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  typedef struct { logic [3:0] idx; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  ecc_err_log uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .ev_ce(ev_ce), .ev_ue(ev_ue), .ev_addr(ev_addr), .ev_data(ev_data),
    .ev_synd(ev_synd), .ev_src(ev_src), .irq(irq));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rd_valid) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL scoreboard: unexpected read data %h", rd_data);
      end else begin
        item_t it;
        it = sb.pop_front();
        n_chk++;
        if (rd_data !== it.exp) begin
          n_bad++;
          $display("FAIL %s: word %0d read %h expected %h", it.tag, it.idx, rd_data, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] i, input logic [31:0] d);
    reg_idx = i; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] i, input logic [31:0] e, input string tag);
    item_t it;
    it.idx = i; it.exp = e; it.tag = tag;
    sb.push_back(it);
    reg_idx = i; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic ev(input logic ce, input logic ue, input logic [33:0] a,
                    input logic [63:0] d, input logic [7:0] s, input logic [13:0] id);
    ev_ce = ce; ev_ue = ue; ev_addr = a; ev_data = d; ev_synd = s; ev_src = id;
    @(negedge clk);
    ev_ce = 0; ev_ue = 0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_chk++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq %b expected %b", tag, irq, e);
    end
  endtask

  task automatic drain;
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: %0d reads unanswered, expected 0", sb.size());
      sb.delete();
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    for (int i = 0; i < 13; i++) rd(i[3:0], (i == 3) ? 32'hFFFF_FFFF : 32'h0, "R1");
    chk_irq(0, "R1");
    // R6 disabled: event ignored
    ev(1, 1, 34'h1_0000_0040, 64'h1111, 8'h11, 14'h0011);
    rd(1, 32'h0, "R6");
    rd(4, 32'h0, "R6");
    rd(12, 32'h0, "R6");
    // R9 control readback, unmapped read
    wr(0, 32'h0001_0000);
    rd(0, 32'h0001_0000, "R9");
    rd(14, 32'h0, "R9");
    // R2 CE capture
    ev(1, 0, 34'h2_DEAD_BEEF, 64'h0123_4567_89AB_CDEF, 8'hA5, 14'h1ABC);
    rd(1, 32'h3, "R2");
    rd(4, 32'hDEAD_BEEF, "R2");
    rd(5, 32'h0000_A502, "R2");
    rd(6, 32'h89AB_CDEF, "R2");
    rd(7, 32'h0123_4567, "R2");
    rd(12, 32'h1ABC_0000, "R2");
    chk_irq(0, "R7 masked after reset");
    // R7 mask behaviour
    wr(3, 32'h7FFF_FFFB);
    rd(3, 32'h7FFF_FFFB, "R9");
    chk_irq(1, "R7 ECC group enabled");
    wr(3, 32'hFFFF_FFFB);
    chk_irq(0, "R7 global mask");
    wr(3, 32'h7FFF_FFFF);
    chk_irq(0, "R7 group mask");
    wr(3, 32'h7FFF_FFFB);
    // R5 frozen bank
    ev(1, 0, 34'h1_1111_2222, 64'hFFFF_0000_FFFF_0000, 8'h3C, 14'h0777);
    rd(4, 32'hDEAD_BEEF, "R5");
    rd(5, 32'h0000_A502, "R5");
    rd(6, 32'h89AB_CDEF, "R5");
    rd(12, 32'h1ABC_0000, "R5");
    // R4 per-bit ack
    wr(2, 32'h1);
    rd(1, 32'h2, "R4");
    chk_irq(1, "R4 partial ack");
    ev(1, 0, 34'h0_0000_0001, 64'h5, 8'h01, 14'h0001);
    rd(4, 32'hDEAD_BEEF, "R5 partial status");
    wr(2, 32'h2);
    rd(1, 32'h0, "R4");
    rd(2, 32'h0, "R4");
    chk_irq(0, "R4 cleared");
    // R3 UE capture using the other enable bit
    wr(0, 32'h0002_0000);
    ev(0, 1, 34'h3_0000_1000, 64'hCAFE_F00D_0BAD_BEEF, 8'h5A, 14'h0123);
    rd(1, 32'hC, "R3");
    rd(8, 32'h0000_1000, "R3");
    rd(9, 32'h0000_5A03, "R3");
    rd(10, 32'h0BAD_BEEF, "R3");
    rd(11, 32'hCAFE_F00D, "R3");
    rd(12, 32'h1ABC_0123, "R3");
    chk_irq(1, "R3 irq");
    wr(2, 32'hC);
    rd(1, 32'h0, "R4");
    // R8 simultaneous
    ev(1, 1, 34'h0_0000_ABCD, 64'h7777_8888_9999_AAAA, 8'hFF, 14'h3FFF);
    rd(1, 32'hF, "R8");
    rd(4, 32'h0000_ABCD, "R8");
    rd(8, 32'h0000_ABCD, "R8");
    rd(12, 32'h3FFF_3FFF, "R8");
    drain();
    report();
  end
endmodule